// File: doc/BRIEF.md
# ADC Serial Data-Out Port Model

This block is a synthesizable device-side model of a delta-sigma converter's serial output port, meant to sit on a chip or an emulation board as a test partner for a serial-port master. A conversion timer runs for a programmable number of system clocks. When it expires, the block latches the 24-bit result, the 5 sub-LSB bits and the range status presented on its result inputs, and then waits in a sleep state.

The master selects the port by pulling the active-low select low. While a conversion is running, the data line acts as a live end-of-conversion flag: high while busy, low once done. After completion the master clocks out a 32-bit word. The first bit can be read before any serial clock edge, and each later bit appears after a falling serial-clock edge. After the last bit the line is driven high. A rising select, whether mid-word or after a full word, drops the word and starts the next conversion.

The select and serial clock inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer before its edges are detected.

Top module: `adc_dout_port`

## Requirements
- R1: While select is high (as seen after synchronization), `sdo_oe` is 0 and serial clock edges leave the output word untouched. A later readout starts again from bit 31.
- R2: While select is low and a conversion is running, `sdo` is 1, and serial clock edges do not advance the word.
- R3: A conversion lasts `conv_len` system clocks. It starts at reset release or at a rising select edge, and a `conv_len` of 0 acts as 1. When it ends, `sdo` falls to 0 while select is low.
- R4: After completion, bit 31 (0, the end-of-conversion flag) is on `sdo` before any serial clock edge. Each synchronized falling serial clock edge presents the next lower bit, so bit 0 appears after the 31st falling edge.
- R5: Word layout: bit 30 = 0; bit 29 = `res_sign`; bit 28 = inverse of `res_sign`; bits 27..5 = `res_mag`; bits 4..0 = `res_sub`. With `res_over` = 1 the word is 0x3FFFFFFF. With `res_under` = 1 and `res_over` = 0 the word is 0x00000000.
- R6: From the 32nd falling serial clock edge until select rises, `sdo` stays 1.
- R7: A rising select in the middle of a word drops the rest of the word and starts a new conversion. The result inputs present at the end of that conversion are the ones latched.
- R8: Between the end of a conversion and the next rising select, changes on the result inputs do not alter the word that is read.
- R9: After a complete 32-bit readout with select held low, no new conversion starts: `sdo` stays 1 and `sdo_oe` stays 1 until select rises.
- R10: Select and serial clock each pass through two synchronizer flops. `sdo_oe` is still 0 one system clock after select falls, and it is 1 within four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low port select, asynchronous |
| sck | input | 1 | Serial clock from the master, asynchronous |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| res_sign | input | 1 | Result sign, 1 for a non-negative input |
| res_mag | input | 23 | Result bits below the MSB |
| res_sub | input | 5 | Sub-LSB bits |
| res_over | input | 1 | Input above positive full scale |
| res_under | input | 1 | Input below negative full scale |
| conv_len | input | CONV_W | Conversion length in system clocks |

## Verification
A busy flag stuck in the wrong state shows up within about four clocks of select falling: `sdo` reads 1 after the word should be ready, or 0 while a conversion should still run. A shift register or bit counter that moves on the wrong events, or on edges while deselected, corrupts the 32-bit word. The first wrong bit is seen at the first sample after the misplaced edge. A word latched at the wrong moment shows up as the wrong result values in the next full readout.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int FRAME_W = 32;
  localparam int MAG_W   = 23;
  localparam int SUB_W   = 5;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;

  // Assemble the output word from the result fields and range status.
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic             sign,
    input logic [MAG_W-1:0] mag,
    input logic [SUB_W-1:0] sub,
    input logic             over,
    input logic             under
  );
    logic [FRAME_W-1:0] f;
    if (over)       f = {4'b0011, {(FRAME_W-4){1'b1}}};
    else if (under) f = '0;
    else            f = {2'b00, sign, ~sign, mag, sub};
    return f;
  endfunction
endpackage

// File: rtl/adp_sync.sv
module adp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adp_conv_timer.sv
module adp_conv_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = (len == '0) ? '0 : len - 1'b1;
  assign done = busy && !start && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end

  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_idle_count_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cnt == '0));
endmodule

// File: rtl/adp_shifter.sv
module adp_shifter
  import adp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               adv,
  output logic [FRAME_W-1:0] word,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic step;
  assign step = adv && (bit_cnt != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '1;
      bit_cnt <= LAST;
    end else if (load) begin
      word    <= frame;
      bit_cnt <= '0;
    end else if (step) begin
      word    <= {word[FRAME_W-2:0], 1'b1};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);
  p_step_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (bit_cnt == $past(bit_cnt) + 1'b1));
endmodule

// File: rtl/adc_dout_port.sv
module adc_dout_port
  import adp_pkg::*;
#(
  parameter int CONV_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              res_sign,
  input  logic [MAG_W-1:0]  res_mag,
  input  logic [SUB_W-1:0]  res_sub,
  input  logic              res_over,
  input  logic              res_under,
  input  logic [CONV_W-1:0] conv_len
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic cs_s, sck_s, cs_d, sck_d;
  logic cs_rise, sck_fall;
  logic busy, conv_done, conv_start, shift_adv;
  logic [FRAME_W-1:0] sh_word;
  logic [CNT_W-1:0]   bit_cnt;

  adp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  adp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_rise    = cs_s && !cs_d;
  assign sck_fall   = !sck_s && sck_d;
  assign conv_start = cs_rise && !busy;
  assign shift_adv  = sck_fall && !cs_s && !busy;

  adp_conv_timer #(.CW(CONV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .len(conv_len),
    .busy(busy), .done(conv_done));

  adp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(conv_done),
    .frame(pack_frame(res_sign, res_mag, res_sub, res_over, res_under)),
    .adv(shift_adv), .word(sh_word), .bit_cnt(bit_cnt));

  always_comb begin
    sdo_oe = !cs_s;
    if (cs_s)      sdo = 1'b0;
    else if (busy) sdo = 1'b1;
    else           sdo = sh_word[FRAME_W-1];
  end

  p_deselect_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !conv_done) |=> $stable(sh_word));
  p_busy_flag_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_s) |-> sdo);
  p_bit30_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cs_s && bit_cnt == 1) |-> !sdo);
  p_tail_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cs_s && bit_cnt == LAST) |-> sdo);
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy);
  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sck_fall) |=> $stable(sh_word));
endmodule

// File: tb/tb_adc_dout_port.sv
module tb_adc_dout_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0;
  logic sdo, sdo_oe;
  logic res_sign = 1'b0, res_over = 1'b0, res_under = 1'b0;
  logic [22:0] res_mag = '0;
  logic [4:0]  res_sub = '0;
  logic [15:0] conv_len = 16'd200;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_dout_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe),
    .res_sign(res_sign), .res_mag(res_mag), .res_sub(res_sub),
    .res_over(res_over), .res_under(res_under), .conv_len(conv_len));

  function automatic logic [31:0] expect_word(input logic s, input logic [22:0] m,
                                              input logic [4:0] u, input logic ov, input logic un);
    logic [31:0] w;
    w = 32'h0;
    if (ov) w = 32'h3FFF_FFFF;
    else if (!un) begin
      w[29] = s; w[28] = !s; w[27:5] = m; w[4:0] = u;
    end
    return w;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_sck();
    sck = 1'b1; wait_clk(6);
    sck = 1'b0; wait_clk(6);
  endtask

  task automatic set_res(input logic s, input logic [22:0] m, input logic [4:0] u,
                         input logic ov, input logic un);
    res_sign = s; res_mag = m; res_sub = u; res_over = ov; res_under = un;
  endtask

  // Reads nbits from bit 31 down; select must already be low and settled.
  task automatic read_bits(input int nbits, output logic [31:0] w);
    w = 32'h0;
    w[31] = sdo;
    for (int k = 1; k < nbits; k++) begin
      pulse_sck();
      w[31-k] = sdo;
    end
  endtask

  task automatic t_reset_and_eoc();
    logic [31:0] w;
    set_res(1'b1, 23'h2A5C3F, 5'h13, 1'b0, 1'b0);
    wait_clk(5); rst_n = 1'b1;
    check("R1 reset oe", {31'b0, sdo_oe}, 32'd0);
    wait_clk(5); cs_n = 1'b0;
    wait_clk(1);
    check("R10 oe after 1 clk", {31'b0, sdo_oe}, 32'd0);
    wait_clk(3);
    check("R10 oe within 4 clk", {31'b0, sdo_oe}, 32'd1);
    check("R2 busy flag", {31'b0, sdo}, 32'd1);
    for (int i = 0; i < 3; i++) pulse_sck();
    check("R2 sck ignored while busy", {31'b0, sdo}, 32'd1);
    wait_clk(105);
    check("R3 still converting", {31'b0, sdo}, 32'd1);
    wait_clk(65);
    check("R3 conversion done", {31'b0, sdo}, 32'd0);
    read_bits(32, w);
    check("R4 R5 R2 full word", w, expect_word(1'b1, 23'h2A5C3F, 5'h13, 1'b0, 1'b0));
    pulse_sck();
    check("R6 high after 32nd fall", {31'b0, sdo}, 32'd1);
    wait_clk(50);
    check("R9 no restart while held low", {30'b0, sdo_oe, sdo}, 32'd3);
  endtask

  task automatic t_deselect_and_sleep();
    logic [31:0] w;
    conv_len = 16'd40;
    set_res(1'b0, 23'h01F0E2, 5'h0A, 1'b0, 1'b0);
    cs_n = 1'b1; wait_clk(6);
    check("R1 oe low when deselected", {31'b0, sdo_oe}, 32'd0);
    wait_clk(60);
    for (int i = 0; i < 5; i++) pulse_sck();
    set_res(1'b1, 23'h7FFFFF, 5'h1F, 1'b0, 1'b0);
    wait_clk(20);
    cs_n = 1'b0; wait_clk(6);
    read_bits(32, w);
    check("R1 R8 word intact after deselected sck and input change", w,
          expect_word(1'b0, 23'h01F0E2, 5'h0A, 1'b0, 1'b0));
  endtask

  task automatic t_abort();
    logic [31:0] w;
    cs_n = 1'b1; wait_clk(60);
    cs_n = 1'b0; wait_clk(6);
    read_bits(10, w);
    check("R4 partial word", {w[31:22], 22'b0},
          {expect_word(1'b1, 23'h7FFFFF, 5'h1F, 1'b0, 1'b0) & 32'hFFC0_0000});
    cs_n = 1'b1;
    set_res(1'b0, 23'h123456, 5'h05, 1'b1, 1'b0);
    wait_clk(10);
    cs_n = 1'b0; wait_clk(6);
    check("R7 abort restarts conversion", {31'b0, sdo}, 32'd1);
    wait_clk(50);
    read_bits(32, w);
    check("R7 R5 over-range word", w, 32'h3FFF_FFFF);
  endtask

  task automatic t_ranges();
    logic [31:0] w;
    cs_n = 1'b1; set_res(1'b1, 23'h55AA55, 5'h11, 1'b0, 1'b1);
    wait_clk(60); cs_n = 1'b0; wait_clk(6);
    read_bits(32, w);
    check("R5 under-range word", w, 32'h0);
    cs_n = 1'b1; set_res(1'b1, 23'h000001, 5'h00, 1'b1, 1'b1);
    wait_clk(60); cs_n = 1'b0; wait_clk(6);
    read_bits(32, w);
    check("R5 over wins over under", w, 32'h3FFF_FFFF);
    cs_n = 1'b1; set_res(1'b0, 23'h400000, 5'h10, 1'b0, 1'b0);
    wait_clk(60); cs_n = 1'b0; wait_clk(6);
    read_bits(32, w);
    check("R5 negative in-range word", w, expect_word(1'b0, 23'h400000, 5'h10, 1'b0, 1'b0));
  endtask

  task automatic t_zero_len();
    conv_len = 16'd0;
    cs_n = 1'b1; wait_clk(8);
    cs_n = 1'b0; wait_clk(6);
    check("R3 zero length acts as one", {31'b0, sdo}, 32'd0);
  endtask

  initial begin
    t_reset_and_eoc();
    t_deselect_and_sleep();
    t_abort();
    t_ranges();
    t_zero_len();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule